// File: doc/BRIEF.md
# Page-Secured Parity-Protected RAM

This block is an on-chip RAM reached through a 64-bit request port. Internally each storage row is 128 bits wide, so one row holds two port-width words. Address bit 3 picks the half of the row that a request touches. Byte strobes limit a write to the enabled bytes. Every byte is stored with one even-parity bit, produced when the byte is written and checked when it is read back.

The address space is split into fixed-size pages. Each page has one security bit: set means secure, clear means non-secure. A request flagged as non-secure that targets a secure page is refused with an error response. A refused write does not change memory. A refused read returns zero.

A small register port holds the page security vector and a sticky parity-error flag that drives the interrupt output. Page size and page count are parameters. The full configuration is 64 pages of 4 KB (256 KB). A simulation can use far fewer, smaller pages.

Top module: `secure_parity_ram`

## Requirements
- R1: After a synchronous reset, `rsp_valid` and `irq` are 0. All page security bits are 1 (secure). The status register reads 0.
- R2: Every request (read or write) produces exactly one `rsp_valid` pulse, two clock cycles after the cycle in which `req_valid` was sampled. `rsp_valid` is 0 in the cycle between.
- R3: A read returns the last data written to that 8-byte word. `req_addr[3]` selects the upper (1) or lower (0) half of a 128-bit row, and the two halves of a row are independent.
- R4: `req_wstrb[i]` enables byte i, which is bits 8i+7:8i of `req_wdata`. Bytes whose strobe bit is clear keep their old contents.
- R5: The page number is `req_addr / PAGE_BYTES`, and security bit p applies to page p. A request with `req_nsec`=0 is never refused.
- R6: A write with `req_nsec`=1 to a secure page responds with `rsp_err`=1 and leaves memory unchanged.
- R7: A read with `req_nsec`=1 to a secure page responds with `rsp_err`=1 and `rsp_rdata`=0. No parity check is made for that read.
- R8: A request with `req_nsec`=1 to a non-secure page is served normally, with `rsp_err`=0.
- R9: Each stored byte carries an even-parity bit. A read of bytes that were written normally never sets the parity flag.
- R10: A write with `req_inject`=1 stores the inverse parity bit for each byte it writes. A later permitted read of the affected half sets `irq` at the same clock edge as that read's response. A read of the other half does not set `irq`.
- R11: `irq` stays at 1 until the register port writes the status register (`reg_sel`=1) with bit 0 set. A write with bit 0 clear leaves `irq` at 1. The status register reads `irq` in bit 0.
- R12: With `reg_sel`=0, the register port accesses the security vector in bits NUM_PAGES-1:0, and the upper bits read as zero. `reg_rdata` reflects the register selected on the previous cycle. A new security vector applies to requests issued after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nsec | input | 1 | 1 = non-secure requester |
| req_inject | input | 1 | Store inverted parity for the bytes written (test aid) |
| req_addr | input | ADDR_W | Byte address; bits 2:0 ignored |
| req_wdata | input | 64 | Write data |
| req_wstrb | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | Response pulse, two cycles after the request |
| rsp_err | output | 1 | Request was refused by the page check |
| rsp_rdata | output | 64 | Read data (zero for writes and refused reads) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = page security vector, 1 = status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read of the selected register |
| irq | output | 1 | Sticky parity-error interrupt |

## Verification
The hardest state to reach from the ports is a stored byte whose parity does not match its data, because normal writes always produce correct parity. The bench uses the injection input to plant bad parity in one half of a row. It then reads the other half, reads the corrupted half with a non-secure request that the page check refuses, and finally reads it with a permitted request. Only the last of these may raise the interrupt. Around that sequence, every word of a small eight-page memory is swept with full and partial strobes, and with secure and non-secure requests under a mixed security vector. The expected results come from a byte-level model.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int PORT_W    = 64;
  localparam int PORT_B    = PORT_W / 8;
  localparam int ROW_LANES = 2 * PORT_B;
  localparam int ROW_SHIFT = $clog2(ROW_LANES);

  localparam logic SEL_ATTR = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  typedef struct packed {
    logic       par;
    logic [7:0] data;
  } cell_t;

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/spr_lane_ram.sv
module spr_lane_ram #(
  parameter int ROWS = 512,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  spr_pkg::cell_t  wcell,
  output spr_pkg::cell_t  rcell
);
  spr_pkg::cell_t mem [ROWS];

  // single-port, read-before-write: maps to one block RAM column
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wcell;
    rcell <= mem[addr];
  end
endmodule

// File: rtl/spr_ctrl_regs.sv
module spr_ctrl_regs #(
  parameter int NUM_PAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_sel,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  input  logic                 par_set,
  output logic [NUM_PAGES-1:0] attr,
  output logic                 irq
);
  import spr_pkg::*;

  logic clr_hit;
  logic unused_wdata;

  assign clr_hit      = reg_we && (reg_sel == SEL_STAT) && reg_wdata[0];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      attr      <= '1;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_ATTR) attr <= reg_wdata[NUM_PAGES-1:0];
      // a new error in the same cycle as a clear wins
      irq       <= par_set | (irq & ~clr_hit);
      reg_rdata <= (reg_sel == SEL_ATTR) ? 64'(attr) : 64'(irq);
    end
  end
endmodule

// File: rtl/spr_resp_stage.sv
module spr_resp_stage (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               in_valid,
  input  logic                               in_write,
  input  logic                               in_refuse,
  input  logic                               in_half,
  input  spr_pkg::cell_t [spr_pkg::ROW_LANES-1:0] row,
  output logic                               rsp_valid,
  output logic                               rsp_err,
  output logic [spr_pkg::PORT_W-1:0]         rsp_rdata,
  output logic                               par_fault
);
  import spr_pkg::*;

  logic s1_valid, s1_write, s1_refuse, s1_half;
  logic [PORT_W-1:0] half_data;
  logic [PORT_B-1:0] bad;
  logic read_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_write  <= 1'b0;
      s1_refuse <= 1'b0;
      s1_half   <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_write  <= in_write;
      s1_refuse <= in_refuse;
      s1_half   <= in_half;
    end
  end

  always_comb begin
    cell_t c;
    half_data = '0;
    bad       = '0;
    for (int b = 0; b < PORT_B; b++) begin
      c = s1_half ? row[PORT_B + b] : row[b];
      half_data[8*b +: 8] = c.data;
      bad[b] = c.par ^ even_par(c.data);
    end
  end

  assign read_ok   = s1_valid & ~s1_write & ~s1_refuse;
  assign par_fault = read_ok & (|bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_err   <= s1_valid & s1_refuse;
      rsp_rdata <= read_ok ? half_data : '0;
    end
  end
endmodule

// File: rtl/secure_parity_ram.sv
module secure_parity_ram #(
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_PAGES  = 2,
  localparam int PAGE_LSB  = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int ADDR_W    = PAGE_LSB + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_nsec,
  input  logic              req_inject,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_wstrb,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              irq
);
  import spr_pkg::*;

  localparam int ROWS  = (PAGE_BYTES * NUM_PAGES) / ROW_LANES;
  localparam int ROW_W = $clog2(ROWS);
  localparam int HALF_BIT = ROW_SHIFT - 1;

  logic [NUM_PAGES-1:0] attr;
  logic [PAGE_W-1:0]    page_idx;
  logic [ROW_W-1:0]     row_addr;
  logic                 refuse;
  logic                 wr_ok;
  logic                 par_fault;
  logic                 unused_low;
  cell_t [ROW_LANES-1:0] row_q;

  assign page_idx   = req_addr[PAGE_LSB +: PAGE_W];
  assign row_addr   = req_addr[ROW_SHIFT +: ROW_W];
  assign unused_low = ^req_addr[HALF_BIT-1:0];
  assign refuse     = req_nsec & attr[page_idx];
  assign wr_ok      = req_valid & req_write & ~refuse;

  for (genvar g = 0; g < ROW_LANES; g++) begin : g_lane
    localparam int   B = g % PORT_B;
    localparam logic H = (g >= PORT_B);
    logic  we;
    cell_t wc;
    assign we      = wr_ok & (req_addr[HALF_BIT] == H) & req_wstrb[B];
    assign wc.data = req_wdata[8*B +: 8];
    assign wc.par  = even_par(req_wdata[8*B +: 8]) ^ req_inject;
    spr_lane_ram #(.ROWS(ROWS)) u_ram (
      .clk   (clk),
      .we    (we),
      .addr  (row_addr),
      .wcell (wc),
      .rcell (row_q[g])
    );
  end

  spr_resp_stage u_resp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_write  (req_write),
    .in_refuse (refuse),
    .in_half   (req_addr[HALF_BIT]),
    .row       (row_q),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .par_fault (par_fault)
  );

  spr_ctrl_regs #(.NUM_PAGES(NUM_PAGES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .par_set   (par_fault),
    .attr      (attr),
    .irq       (irq)
  );
endmodule

// File: rtl/spr_chk.sv
module spr_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_nsec,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_rdata,
  input logic        irq,
  input logic        reg_we,
  input logic        reg_sel,
  input logic [63:0] reg_wdata
);
  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ##1 rsp_valid);

  // R2
  resp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));

  // R5
  secure_never_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_nsec) |=> ##1 !rsp_err);

  // R7
  refused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> rsp_rdata == 64'd0);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (rsp_valid && !rsp_err));

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_we && reg_sel && reg_wdata[0])) |=> irq);
endmodule

bind secure_parity_ram spr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_nsec  (req_nsec),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata)
);

// File: tb/secure_parity_ram_test.sv
module secure_parity_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int PB    = 64;
  localparam int NP    = 8;
  localparam int AW    = 9;
  localparam int WORDS = PB * NP / 8;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_nsec = 0, req_inject = 0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_wstrb = '0;
  logic rsp_valid, rsp_err, irq;
  logic [63:0] rsp_rdata, reg_rdata;
  logic reg_we = 0, reg_sel = 0;
  logic [63:0] reg_wdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mem_m [PB*NP];
  logic [NP-1:0] attr_m = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  secure_parity_ram #(.PAGE_BYTES(PB), .NUM_PAGES(NP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_nsec(req_nsec), .req_inject(req_inject), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int w, input int k);
    return (64'h9E3779B97F4A7C15 * 64'(w * 131 + k * 977 + 1)) ^ 64'(k);
  endfunction

  function automatic logic [63:0] model_word(input int w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = mem_m[w*8 + b];
    return r;
  endfunction

  // one request; returns mid-cycle valid, response valid, data, error
  task automatic access(input bit wr, input bit ns, input bit inj, input int w,
                        input logic [63:0] wd, input logic [7:0] st,
                        output logic vmid, output logic vld,
                        output logic [63:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_nsec = ns; req_inject = inj;
    req_addr = AW'(w * 8); req_wdata = wd; req_wstrb = st;
    @(negedge clk);
    req_valid = 0; req_inject = 0;
    vmid = rsp_valid;
    @(negedge clk);
    vld = rsp_valid; rd = rsp_rdata; er = rsp_err;
    if (wr && !(ns && attr_m[w / (PB/8)]))
      for (int b = 0; b < 8; b++)
        if (st[b]) mem_m[w*8 + b] = wd[8*b +: 8];
  endtask

  task automatic wr_word(input bit ns, input bit inj, input int w, input logic [63:0] wd,
                         input logic [7:0] st, input string tag);
    logic vm, v, e; logic [63:0] d;
    logic exp_e;
    exp_e = ns && attr_m[w / (PB/8)];
    access(1, ns, inj, w, wd, st, vm, v, d, e);
    chk(v && e == exp_e, tag, {62'd0, v, e}, {62'd0, 1'b1, exp_e});
  endtask

  task automatic rd_word(input bit ns, input int w, input string tag);
    logic vm, v, e; logic [63:0] d, exp_d;
    logic exp_e;
    exp_e = ns && attr_m[w / (PB/8)];
    exp_d = exp_e ? 64'd0 : model_word(w);
    access(0, ns, 0, w, 64'd0, 8'd0, vm, v, d, e);
    chk(v && e == exp_e && d == exp_d, tag, d, exp_d);
  endtask

  task automatic reg_write(input logic sel, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read(input logic sel, output logic [63:0] d);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] r;
    logic vm, v, e; logic [63:0] d;
    for (int i = 0; i < PB*NP; i++) mem_m[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    chk(rsp_valid == 0 && irq == 0, "R1 outputs after reset", {62'd0, rsp_valid, irq}, 64'd0);
    reg_read(0, r);
    chk(r == 64'h0000_0000_0000_00FF, "R1 R12 security vector after reset", r, 64'hFF);
    reg_read(1, r);
    chk(r == 64'd0, "R1 status after reset", r, 64'd0);

    // R2 latency: valid only in the second cycle
    access(1, 0, 0, 0, pat(0, 0), 8'hFF, vm, v, d, e);
    chk(vm == 0 && v == 1, "R2 write response timing", {62'd0, vm, v}, 64'd1);
    @(negedge clk);
    chk(rsp_valid == 0, "R2 single pulse", {63'd0, rsp_valid}, 64'd0);
    access(0, 0, 0, 0, 64'd0, 8'd0, vm, v, d, e);
    chk(vm == 0 && v == 1 && d == model_word(0), "R2 read response timing", d, model_word(0));

    // R3 fill every word, then read all back
    for (int w = 0; w < WORDS; w++) wr_word(0, 0, w, pat(w, 1), 8'hFF, "R3 fill write");
    for (int w = 0; w < WORDS; w++) rd_word(0, w, "R3 readback per half");

    // R4 partial strobe sweep
    for (int w = 0; w < WORDS; w++) wr_word(0, 0, w, pat(w, 2), 8'((w * 37 + 5) & 8'hFF), "R4 strobe write");
    for (int w = 0; w < WORDS; w++) rd_word(0, w, "R4 strobe readback");

    // R5..R8 page security under a mixed vector (pages 1,3,4,6 secure)
    reg_write(0, 64'h5A);
    attr_m = 8'h5A;
    reg_read(0, r);
    chk(r == 64'h5A, "R12 security vector readback", r, 64'h5A);
    for (int p = 0; p < NP; p++) begin
      int w;
      w = p * (PB/8) + 3;
      wr_word(1, 0, w, pat(w, 3), 8'hFF, "R6 R8 non-secure write response");
      rd_word(1, w, "R7 R8 non-secure read");
      rd_word(0, w, "R5 R6 secure read after non-secure write");
      wr_word(0, 0, w + 1, pat(w, 4), 8'h3C, "R5 secure write to any page");
      rd_word(0, w + 1, "R5 secure readback");
    end

    // R9 normal data never flags parity
    chk(irq == 0, "R9 no parity error after sweeps", {63'd0, irq}, 64'd0);

    // R10 plant bad parity in low half of row 5 (word 10, page 1 secure)
    wr_word(0, 1, 10, pat(10, 5), 8'h0F, "R10 inject write");
    rd_word(0, 11, "R10 other half read");
    chk(irq == 0, "R10 other half leaves irq clear", {63'd0, irq}, 64'd0);
    rd_word(1, 10, "R7 refused read of corrupted word");
    chk(irq == 0, "R7 refused read skips parity check", {63'd0, irq}, 64'd0);
    rd_word(0, 10, "R10 data of corrupted word");
    chk(irq == 1, "R10 irq with read response", {63'd0, irq}, 64'd1);

    // R11 sticky behaviour
    reg_write(1, 64'h0);
    chk(irq == 1, "R11 write of 0 keeps irq", {63'd0, irq}, 64'd1);
    reg_read(1, r);
    chk(r == 64'd1, "R11 status shows flag", r, 64'd1);
    rd_word(0, 0, "R11 clean read");
    chk(irq == 1, "R11 irq held across clean read", {63'd0, irq}, 64'd1);
    reg_write(1, 64'h1);
    chk(irq == 0, "R11 write 1 clears irq", {63'd0, irq}, 64'd0);
    rd_word(0, 10, "R10 reread corrupted word");
    chk(irq == 1, "R10 irq raised again", {63'd0, irq}, 64'd1);
    reg_write(1, 64'h1);
    wr_word(0, 0, 10, pat(10, 6), 8'hFF, "R9 rewrite word");
    rd_word(0, 10, "R9 rewritten data");
    chk(irq == 0, "R9 fresh parity is clean", {63'd0, irq}, 64'd0);

    // R12 opening all pages lets non-secure traffic through
    reg_write(0, 64'h0);
    attr_m = 8'h00;
    wr_word(1, 0, 9, pat(9, 7), 8'hFF, "R12 R8 non-secure write after open");
    rd_word(1, 9, "R12 R8 non-secure read after open");
    reg_read(0, r);
    chk(r == 64'd0, "R12 vector readback after open", r, 64'd0);

    finish_run();
  end
endmodule